// File: doc/BRIEF.md
# Flag-Based Branch Condition Unit

This unit decides whether a conditional control transfer happens, based on the processor status flags. A 4-bit condition code selects one of sixteen tests over the overflow, carry, zero, sign and saturation flags. In branch mode, a true test makes the unit add a 9-bit signed displacement to the address of the branch instruction. A false test makes it step past the 2-byte instruction.

The same evaluator also serves a set-flag operation. That operation writes a full data word into a destination register: 1 when the test holds and 0 when it does not. The condition code for set-flag is taken from the low four bits of its operand.

The unit registers its result one clock after a request is presented. Instruction fetch, decode and register writeback belong to the surrounding pipeline.

Top module: `flag_branch_unit`

## Requirements
- R1: After reset, outValid, taken, nextPc and setResult are all zero.
- R2: outValid is 1 exactly one cycle after inValid was 1. In a cycle with no request, outValid and taken read 0, while nextPc and setResult keep their last values.
- R3: The flag vector bit positions are bit0 overflow, bit1 carry, bit2 zero, bit3 sign and bit4 saturation. Codes 0 and 8 test overflow set and clear. Codes 1 and 9 test carry set and clear. Codes 2 and 10 test zero set and clear.
- R4: Code 3 holds when carry or zero is set. Code 11 holds when both are clear.
- R5: Code 4 holds when sign is set and code 12 when it is clear. Code 13 holds when saturation is set.
- R6: Code 6 holds when sign xor overflow is 1. Code 14 holds when it is 0.
- R7: Code 7 holds when zero is set or sign xor overflow is 1. Code 15 is the complement of code 7.
- R8: Code 5 always holds.
- R9: opSel 0 selects branch. When the test holds, taken is 1 and nextPc is pcIn plus the sign-extended 9-bit displacement, modulo 2^PC_W. This covers displacements from -256 to +255.
- R10: When a branch test fails, and for every set-flag request, nextPc is pcIn plus 2 (modulo 2^PC_W) and taken is 0.
- R11: opSel 1 selects set-flag. setResult is the full-width word 1 when the test holds and 0 otherwise. A branch request writes setResult as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request present this cycle |
| opSel | input | 1 | 0 = branch, 1 = set-flag |
| condCode | input | 4 | Condition code (low operand bits for set-flag) |
| flags | input | 5 | Status flags {sat, sign, zero, carry, overflow} |
| pcIn | input | PC_W | Address of the requesting instruction |
| disp | input | 9 | Signed branch displacement |
| outValid | output | 1 | Result registered this cycle |
| taken | output | 1 | Branch transfer happens |
| nextPc | output | PC_W | Address of the next instruction |
| setResult | output | DATA_W | Set-flag word, 0 or 1 |

## Verification
The assertions assume that opSel, condCode, flags, pcIn and disp are known whenever inValid is 1, and that inValid is held low throughout reset. Their $past terms therefore only see requests made after reset. The bench drives every input from the falling clock edge and keeps inValid low while rstN is asserted. It sweeps all sixteen codes across all 32 flag patterns in both modes, with idle gaps between bursts. It also applies the displacement extremes and program counters near the top of the address space, so that wrap-around is exercised without leaving the assumed input ranges.

// File: rtl/bcu_pkg.sv
package bcu_pkg;
  localparam int CODE_W   = 4;
  localparam int INSN_LEN = 2;

  typedef struct packed {
    logic sat;
    logic sgn;
    logic zero;
    logic carry;
    logic ovf;
  } flagVec_t;

  typedef enum logic {
    OP_BRANCH = 1'b0,
    OP_SETF   = 1'b1
  } opSel_e;

  typedef struct packed {
    logic capture;
    logic isSetf;
    logic condTrue;
    logic takeJump;
  } ctrlStrobe_t;
endpackage

// File: rtl/bcu_ctrl.sv
module bcu_ctrl
  import bcu_pkg::*;
(
  input  logic              inValid,
  input  logic              opSel,
  input  logic [CODE_W-1:0] condCode,
  input  flagVec_t          flagIn,
  output ctrlStrobe_t       strobe
);
  logic baseTest;
  logic signOvf;
  logic result;

  assign signOvf = flagIn.sgn ^ flagIn.ovf;

  // The low three bits pick a primary test; the top bit inverts it.
  always_comb begin
    unique case (condCode[2:0])
      3'd0: baseTest = flagIn.ovf;
      3'd1: baseTest = flagIn.carry;
      3'd2: baseTest = flagIn.zero;
      3'd3: baseTest = flagIn.carry | flagIn.zero;
      3'd4: baseTest = flagIn.sgn;
      3'd5: baseTest = 1'b1;
      3'd6: baseTest = signOvf;
      default: baseTest = flagIn.zero | signOvf;
    endcase
  end

  // Code 13 does not invert code 5; it is a dedicated saturation test.
  always_comb begin
    if (condCode == CODE_W'(13)) result = flagIn.sat;
    else                         result = baseTest ^ condCode[3];
  end

  always_comb begin
    strobe.capture  = inValid;
    strobe.isSetf   = (opSel_e'(opSel) == OP_SETF);
    strobe.condTrue = result;
    strobe.takeJump = inValid && (opSel_e'(opSel) == OP_BRANCH) && result;
  end
endmodule

// File: rtl/bcu_datapath.sv
module bcu_datapath
  import bcu_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int DATA_W = 32,
  parameter int DISP_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [PC_W-1:0]   pcIn,
  input  logic [DISP_W-1:0] disp,
  output logic              outValid,
  output logic              taken,
  output logic [PC_W-1:0]   nextPc,
  output logic [DATA_W-1:0] setResult
);
  localparam int EXT_W = PC_W - DISP_W;

  logic [PC_W-1:0] dispExt;
  logic [PC_W-1:0] jumpPc;
  logic [PC_W-1:0] seqPc;

  assign dispExt = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign jumpPc  = pcIn + dispExt;
  assign seqPc   = pcIn + PC_W'(INSN_LEN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      taken     <= 1'b0;
      nextPc    <= '0;
      setResult <= '0;
    end else begin
      outValid <= strobe.capture;
      taken    <= strobe.takeJump;
      if (strobe.capture) begin
        nextPc    <= strobe.takeJump ? jumpPc : seqPc;
        setResult <= (strobe.isSetf && strobe.condTrue) ? DATA_W'(1) : '0;
      end
    end
  end
endmodule

// File: rtl/flag_branch_unit.sv
module flag_branch_unit
  import bcu_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int DATA_W = 32,
  parameter int DISP_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              opSel,
  input  logic [3:0]        condCode,
  input  logic [4:0]        flags,
  input  logic [PC_W-1:0]   pcIn,
  input  logic [DISP_W-1:0] disp,
  output logic              outValid,
  output logic              taken,
  output logic [PC_W-1:0]   nextPc,
  output logic [DATA_W-1:0] setResult
);
  ctrlStrobe_t strobe;
  flagVec_t    flagIn;

  assign flagIn = flagVec_t'(flags);

  bcu_ctrl u_ctrl (
    .inValid (inValid),
    .opSel   (opSel),
    .condCode(condCode),
    .flagIn  (flagIn),
    .strobe  (strobe)
  );

  bcu_datapath #(
    .PC_W  (PC_W),
    .DATA_W(DATA_W),
    .DISP_W(DISP_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .pcIn     (pcIn),
    .disp     (disp),
    .outValid (outValid),
    .taken    (taken),
    .nextPc   (nextPc),
    .setResult(setResult)
  );
endmodule

// File: rtl/bcu_checks.sv
module bcu_checks #(
  parameter int PC_W   = 32,
  parameter int DATA_W = 32,
  parameter int DISP_W = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              opSel,
  input logic [3:0]        condCode,
  input logic [4:0]        flags,
  input logic [PC_W-1:0]   pcIn,
  input logic [DISP_W-1:0] disp,
  input logic              outValid,
  input logic              taken,
  input logic [PC_W-1:0]   nextPc,
  input logic [DATA_W-1:0] setResult
);
  logic [PC_W-1:0] dispWide;
  assign dispWide = {{(PC_W-DISP_W){disp[DISP_W-1]}}, disp};

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    outValid == $past(inValid));

  a_r2_idle_no_jump: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> !taken);

  a_r11_setf_never_jumps: assert property (@(posedge clk) disable iff (!rstN)
    taken |-> ($past(opSel) == 1'b0));

  a_r11_word_is_bit: assert property (@(posedge clk) disable iff (!rstN)
    setResult[DATA_W-1:1] == '0);

  a_r8_always_taken: assert property (@(posedge clk) disable iff (!rstN)
    ($past(inValid) && !$past(opSel) && $past(condCode) == 4'd5) |-> taken);

  a_r3_ovf_test: assert property (@(posedge clk) disable iff (!rstN)
    ($past(inValid) && !$past(opSel) && $past(condCode) == 4'd0) |-> (taken == $past(flags[0])));

  a_r10_seq_pc: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !taken) |-> (nextPc == $past(pcIn) + PC_W'(2)));

  a_r9_jump_pc: assert property (@(posedge clk) disable iff (!rstN)
    taken |-> (nextPc == $past(pcIn) + $past(dispWide)));
endmodule

bind flag_branch_unit bcu_checks #(
  .PC_W  (PC_W),
  .DATA_W(DATA_W),
  .DISP_W(DISP_W)
) u_checks (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .opSel    (opSel),
  .condCode (condCode),
  .flags    (flags),
  .pcIn     (pcIn),
  .disp     (disp),
  .outValid (outValid),
  .taken    (taken),
  .nextPc   (nextPc),
  .setResult(setResult)
);

// File: tb/flag_branch_unit_tb.sv
module flag_branch_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W   = 32;
  localparam int DATA_W = 32;
  localparam int DISP_W = 9;
  localparam int WATCHDOG_CYCLES = 100000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              inValid = 1'b0;
  logic              opSel = 1'b0;
  logic [3:0]        condCode = '0;
  logic [4:0]        flags = '0;
  logic [PC_W-1:0]   pcIn = '0;
  logic [DISP_W-1:0] disp = '0;
  logic              outValid;
  logic              taken;
  logic [PC_W-1:0]   nextPc;
  logic [DATA_W-1:0] setResult;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic              expValid = 0;
  logic              expTaken = 0;
  logic [PC_W-1:0]   expPc = '0;
  logic [DATA_W-1:0] expSet = '0;
  logic [3:0]        lastCode = '0;
  logic              lastOp = 0;
  logic              lastHit = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flag_branch_unit #(.PC_W(PC_W), .DATA_W(DATA_W), .DISP_W(DISP_W)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .condCode(condCode), .flags(flags), .pcIn(pcIn), .disp(disp),
    .outValid(outValid), .taken(taken), .nextPc(nextPc), .setResult(setResult)
  );

  // Reference test: flags = {sat, sign, zero, carry, overflow}
  function automatic bit refCond(input int code, input logic [4:0] f);
    bit ov = f[0], cy = f[1], z = f[2], s = f[3], sat = f[4];
    case (code)
      0: return ov;            8:  return !ov;
      1: return cy;            9:  return !cy;
      2: return z;             10: return !z;
      3: return cy || z;       11: return !cy && !z;
      4: return s;             12: return !s;
      5: return 1;             13: return sat;
      6: return s != ov;       14: return s == ov;
      7: return z || (s != ov);
      default: return !(z || (s != ov));
    endcase
  endfunction

  function automatic string reqOf(input int code);
    case (code)
      0, 1, 2, 8, 9, 10: return "R3";
      3, 11:             return "R4";
      4, 12, 13:         return "R5";
      6, 14:             return "R6";
      7, 15:             return "R7";
      default:           return "R8";
    endcase
  endfunction

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compareAll();
    string condReq;
    condReq = lastOp ? "R11" : reqOf(lastCode);
    check("R2", "outValid", outValid, expValid);
    check(expValid ? condReq : "R2", "taken", taken, expTaken);
    check(lastHit && !lastOp ? "R9" : "R10", "nextPc", nextPc, expPc);
    check(lastOp ? condReq : "R11", "setResult", setResult, expSet);
  endtask

  task automatic step(input bit v, input bit op, input int code, input int f,
                      input logic [PC_W-1:0] pc, input int d);
    int dv;
    bit hit;
    inValid  = v;
    opSel    = op;
    condCode = 4'(code);
    flags    = 5'(f);
    pcIn     = pc;
    disp     = DISP_W'(d);
    @(posedge clk);
    dv = d & 511;
    if (dv >= 256) dv -= 512;
    hit = refCond(code & 15, 5'(f));
    expValid = v;
    expTaken = v && !op && hit;
    if (v) begin
      lastCode = 4'(code);
      lastOp   = op;
      lastHit  = hit;
      expPc    = (!op && hit) ? pc + PC_W'(dv) : pc + PC_W'(2);
      expSet   = (op && hit) ? DATA_W'(1) : '0;
    end
    @(negedge clk);
    compareAll();
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG_CYCLES, 0);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "outValid", outValid, 0);
    check("R1", "taken", taken, 0);
    check("R1", "nextPc", nextPc, 0);
    check("R1", "setResult", setResult, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R3..R8 with R9/R10 branch; R11 set-flag: full sweep
    for (int op = 0; op < 2; op++) begin
      for (int code = 0; code < 16; code++) begin
        for (int f = 0; f < 32; f++) begin
          step(1, op[0], code, f, PC_W'(32'h1000 + code * 64 + f * 2), (f * 37 + code) - 200);
        end
        // R2: idle cycle keeps nextPc/setResult, clears taken
        step(0, 0, 5, 0, 32'hDEAD_BEE0, 3);
      end
    end

    // R9: displacement extremes and wrap-around
    step(1, 0, 5, 0, 32'h0000_0100, -256);
    step(1, 0, 5, 0, 32'h0000_0100, 255);
    step(1, 0, 5, 0, 32'hFFFF_FFF0, 100);
    step(1, 0, 5, 0, 32'h0000_0004, -8);
    // R10: sequential wrap at top of address space
    step(1, 0, 13, 0, 32'hFFFF_FFFE, 40);
    step(1, 1, 13, 16, 32'hFFFF_FFFF, 40);
    // R2: back-to-back requests then idle gaps
    step(1, 0, 7, 4, 32'h2000, -2);
    step(0, 1, 7, 4, 32'h3000, 10);
    step(0, 1, 7, 4, 32'h3000, 10);
    step(1, 1, 15, 0, 32'h4000, 0);

    finishRun();
  end
endmodule